// File: doc/BRIEF.md
# Indirect Table Access Port

This block puts several internal lookup tables behind two 64-bit registers. Software first writes an address register that names a table and an entry index, then reads or writes a data register to reach that entry. An optional auto-increment bit moves the index forward after each data access. The index wraps inside the selected table, so a whole table can be loaded or dumped with one address write followed by back-to-back data accesses.

Three tables hold state: an interrupt-vector table, a window-descriptor table and a plain translation table. Two more table codes are recognised but have no storage behind them. Writes to the interrupt-vector table keep only its routing fields. Each window-descriptor entry is decoded into enable, base and size-mask outputs. Any write to a window entry pulses a strobe that carries the entry index, so the logic that consumes the windows can re-evaluate that entry.

The register port is a single-cycle request with a registered response one cycle later. Only full 64-bit accesses at 8-byte aligned offsets are accepted.

Top module: `tbl_access_port`

## Requirements
- R1: The address register sits at offset 0x0 and keeps only three fields: auto-increment at bit 63, table select at bits 51:48 and entry index at bits 15:0. All other written bits read back as zero.
- R2: A read of the data register at offset 0x8 returns the entry at the current index of the selected table. `rsp_valid` and `rsp_rdata` appear in the cycle after the request.
- R3: With auto-increment set, each data access to a known table sets the index to (index+1) AND (table depth-1). The new index can be read back from the address register.
- R4: With auto-increment clear, data accesses leave the address register unchanged.
- R5: A data access whose select code names no table (codes other than 0x2, 0x3, 0x5, 0x7 and 0x9) sets the sticky `err_table` flag. It changes no entry and no index, and a read returns zero.
- R6: Select codes 0x3 (16 entries) and 0x9 (32 entries) are recognised but hold no storage. Reads from them return zero, writes to them are discarded, and the index still advances.
- R7: A write to the interrupt-vector table (code 0x2) stores only server bits 47:40, priority bits 39:32 and node bits 27:24. All other bits are cleared.
- R8: The vector lookup port returns the stored server field shifted right by two, together with the priority and node fields of entry `ivt_rd_idx`.
- R9: For a window entry (code 0x5), the enable is bit 63. The base is bits 27:0 shifted left by 20, and the size mask is bits 55:28 shifted left by 20 with bits 63:50 forced to one. When the enable is clear, base and mask read as zero.
- R10: When bit 62 of a window entry is set (single-partition mode), bits 24:0 of its decoded base are zero.
- R11: Every data write to the window table pulses `win_upd_valid` for one cycle in the cycle after the write, with the entry index on `win_upd_idx`. Writes to other tables do not pulse it.
- R12: A request that is not full-width or not 8-byte aligned sets the sticky `err_access` flag and has no effect. A read of that kind returns zero.
- R13: After reset the address register, every table entry, both error flags and the strobe are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_full | input | 1 | Request is a full 64-bit access |
| req_off | input | 4 | Byte offset of the register |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | 64 | Registered read data |
| err_access | output | 1 | Sticky: bad width or alignment seen |
| err_table | output | 1 | Sticky: data access to an unknown table |
| ivt_rd_idx | input | IVT_IW | Vector lookup index |
| ivt_server | output | 8 | Effective server number of the looked-up entry |
| ivt_prio | output | 8 | Priority of the looked-up entry |
| ivt_node | output | 4 | Node field of the looked-up entry |
| win_en | output | WIN_DEPTH | Per-window enable |
| win_base | output | 64*WIN_DEPTH | Decoded window bases, entry i at slice i |
| win_mask | output | 64*WIN_DEPTH | Decoded window size masks, entry i at slice i |
| win_upd_valid | output | 1 | Window re-evaluate strobe |
| win_upd_idx | output | WIN_IW | Index of the rewritten window entry |

## Verification
The hardest state to reach is the index wrap. It only appears when a data access with auto-increment lands exactly on the last entry of a table. Whether the wrap is right depends on which table's depth is applied, so an error shows up only for tables of different sizes. The stimulus places the index one or two entries below the end of an 8-entry table and of a 16-entry storage-less table, then reads the address register back. A second hard case is a window write that clears the enable bit. It must still pulse the strobe while the decoded outputs fall to zero, and the bench checks both in the same cycle.

// File: rtl/tap_pkg.sv
package tap_pkg;
  localparam int DW    = 64;
  localparam int IDX_W = 16;
  localparam int SEL_W = 4;

  localparam int AR_AUTO   = 63;
  localparam int AR_SEL_LO = 48;
  localparam logic [DW-1:0] AR_KEEP = 64'h800F_0000_0000_FFFF;

  localparam logic [SEL_W-1:0] SEL_IVT   = 4'h2;
  localparam logic [SEL_W-1:0] SEL_STUBA = 4'h3;
  localparam logic [SEL_W-1:0] SEL_WIN   = 4'h5;
  localparam logic [SEL_W-1:0] SEL_XLT   = 4'h7;
  localparam logic [SEL_W-1:0] SEL_STUBB = 4'h9;

  localparam logic [DW-1:0] IVT_KEEP  = 64'h0000_FFFF_0F00_0000;
  localparam logic [DW-1:0] ALL_KEEP  = '1;
  localparam logic [DW-1:0] WIN_TOP14 = 64'hFFFC_0000_0000_0000;

  typedef enum logic [2:0] {TK_NONE, TK_IVT, TK_WIN, TK_XLT, TK_STUB} tbl_kind_e;

  function automatic logic [IDX_W-1:0] idx_advance(input logic [IDX_W-1:0] idx,
                                                   input logic [IDX_W-1:0] msk);
    return (idx + IDX_W'(1)) & msk;
  endfunction

  function automatic logic [DW-1:0] win_base_of(input logic [DW-1:0] e);
    logic [DW-1:0] b;
    b = {16'h0, e[27:0], 20'h0};
    if (e[62]) b[24:0] = '0;
    return b;
  endfunction

  function automatic logic [DW-1:0] win_mask_of(input logic [DW-1:0] e);
    return {16'h0, e[55:28], 20'h0} | WIN_TOP14;
  endfunction

  function automatic logic [7:0] ivt_server_of(input logic [DW-1:0] e);
    return e[47:40] >> 2;
  endfunction

  function automatic logic [7:0] ivt_prio_of(input logic [DW-1:0] e);
    return e[39:32];
  endfunction

  function automatic logic [3:0] ivt_node_of(input logic [DW-1:0] e);
    return e[27:24];
  endfunction
endpackage

// File: rtl/tap_sel_decode.sv
module tap_sel_decode
  import tap_pkg::*;
#(
  parameter int IVT_DEPTH   = 8,
  parameter int WIN_DEPTH   = 4,
  parameter int XLT_DEPTH   = 8,
  parameter int STUBA_DEPTH = 16,
  parameter int STUBB_DEPTH = 32
) (
  input  logic [SEL_W-1:0] sel,
  output tbl_kind_e        kind,
  output logic [IDX_W-1:0] idx_mask
);
  always_comb begin
    kind     = TK_NONE;
    idx_mask = '0;
    unique case (sel)
      SEL_IVT:   begin kind = TK_IVT;  idx_mask = IDX_W'(IVT_DEPTH - 1);   end
      SEL_WIN:   begin kind = TK_WIN;  idx_mask = IDX_W'(WIN_DEPTH - 1);   end
      SEL_XLT:   begin kind = TK_XLT;  idx_mask = IDX_W'(XLT_DEPTH - 1);   end
      SEL_STUBA: begin kind = TK_STUB; idx_mask = IDX_W'(STUBA_DEPTH - 1); end
      SEL_STUBB: begin kind = TK_STUB; idx_mask = IDX_W'(STUBB_DEPTH - 1); end
      default:   begin kind = TK_NONE; idx_mask = '0; end
    endcase
  end
endmodule

// File: rtl/tap_table.sv
module tap_table
  import tap_pkg::*;
#(
  parameter int            DEPTH = 8,
  parameter logic [DW-1:0] KEEP  = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rd_o,
  output logic [DW-1:0]    ent_o [DEPTH]
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent_o[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < DEPTH; i++)
        if (idx == IDX_W'(i)) ent_o[i] <= wdata & KEEP;
    end
  end

  always_comb begin
    rd_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (idx == IDX_W'(i)) rd_o = ent_o[i];
  end
endmodule

// File: rtl/tap_win_decode.sv
module tap_win_decode
  import tap_pkg::*;
#(
  parameter int WIN_DEPTH = 4
) (
  input  logic [DW-1:0]           ent [WIN_DEPTH],
  output logic [WIN_DEPTH-1:0]    en,
  output logic [DW*WIN_DEPTH-1:0] base,
  output logic [DW*WIN_DEPTH-1:0] mask
);
  for (genvar g = 0; g < WIN_DEPTH; g++) begin : g_win
    assign en[g]              = ent[g][63];
    assign base[g*DW +: DW]   = ent[g][63] ? win_base_of(ent[g]) : '0;
    assign mask[g*DW +: DW]   = ent[g][63] ? win_mask_of(ent[g]) : '0;
  end
endmodule

// File: rtl/tbl_access_port.sv
module tbl_access_port
  import tap_pkg::*;
#(
  parameter int IVT_DEPTH   = 8,
  parameter int WIN_DEPTH   = 4,
  parameter int XLT_DEPTH   = 8,
  parameter int STUBA_DEPTH = 16,
  parameter int STUBB_DEPTH = 32,
  localparam int IVT_IW     = $clog2(IVT_DEPTH),
  localparam int WIN_IW     = $clog2(WIN_DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic                    req_full,
  input  logic [3:0]              req_off,
  input  logic [63:0]             req_wdata,
  output logic                    rsp_valid,
  output logic [63:0]             rsp_rdata,
  output logic                    err_access,
  output logic                    err_table,
  input  logic [IVT_IW-1:0]       ivt_rd_idx,
  output logic [7:0]              ivt_server,
  output logic [7:0]              ivt_prio,
  output logic [3:0]              ivt_node,
  output logic [WIN_DEPTH-1:0]    win_en,
  output logic [64*WIN_DEPTH-1:0] win_base,
  output logic [64*WIN_DEPTH-1:0] win_mask,
  output logic                    win_upd_valid,
  output logic [WIN_IW-1:0]       win_upd_idx
);
  logic [DW-1:0]    addr_q;
  tbl_kind_e        kind;
  logic [IDX_W-1:0] idx_mask;
  logic [IDX_W-1:0] cur_idx;

  // Request classification, named for the checker
  logic acc_ok, is_addr, is_data, bad_acc, data_go, bad_tbl;
  logic wr_ivt, wr_win, wr_xlt;

  logic [DW-1:0] ivt_rd, win_rd, xlt_rd, tbl_rd;
  logic [DW-1:0] ivt_ent [IVT_DEPTH];
  logic [DW-1:0] win_ent [WIN_DEPTH];
  logic [DW-1:0] xlt_ent [XLT_DEPTH];
  logic [DW-1:0] ivt_pick;

  tap_sel_decode #(
    .IVT_DEPTH(IVT_DEPTH), .WIN_DEPTH(WIN_DEPTH), .XLT_DEPTH(XLT_DEPTH),
    .STUBA_DEPTH(STUBA_DEPTH), .STUBB_DEPTH(STUBB_DEPTH)
  ) u_dec (
    .sel(addr_q[AR_SEL_LO +: SEL_W]),
    .kind(kind),
    .idx_mask(idx_mask)
  );

  assign cur_idx = addr_q[IDX_W-1:0] & idx_mask;

  assign acc_ok  = req_valid && req_full && (req_off[2:0] == 3'b000);
  assign is_addr = acc_ok && !req_off[3];
  assign is_data = acc_ok && req_off[3];
  assign bad_acc = req_valid && !acc_ok;
  assign data_go = is_data && (kind != TK_NONE);
  assign bad_tbl = is_data && (kind == TK_NONE);

  assign wr_ivt = data_go && req_write && (kind == TK_IVT);
  assign wr_win = data_go && req_write && (kind == TK_WIN);
  assign wr_xlt = data_go && req_write && (kind == TK_XLT);

  tap_table #(.DEPTH(IVT_DEPTH), .KEEP(IVT_KEEP)) u_ivt (
    .clk(clk), .rst_n(rst_n), .we(wr_ivt), .idx(cur_idx),
    .wdata(req_wdata), .rd_o(ivt_rd), .ent_o(ivt_ent)
  );

  tap_table #(.DEPTH(WIN_DEPTH), .KEEP(ALL_KEEP)) u_win (
    .clk(clk), .rst_n(rst_n), .we(wr_win), .idx(cur_idx),
    .wdata(req_wdata), .rd_o(win_rd), .ent_o(win_ent)
  );

  tap_table #(.DEPTH(XLT_DEPTH), .KEEP(ALL_KEEP)) u_xlt (
    .clk(clk), .rst_n(rst_n), .we(wr_xlt), .idx(cur_idx),
    .wdata(req_wdata), .rd_o(xlt_rd), .ent_o(xlt_ent)
  );

  tap_win_decode #(.WIN_DEPTH(WIN_DEPTH)) u_wdec (
    .ent(win_ent), .en(win_en), .base(win_base), .mask(win_mask)
  );

  always_comb begin
    unique case (kind)
      TK_IVT:  tbl_rd = ivt_rd;
      TK_WIN:  tbl_rd = win_rd;
      TK_XLT:  tbl_rd = xlt_rd;
      default: tbl_rd = '0;
    endcase
  end

  // Address register: software load, or index advance after a data access
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (is_addr && req_write) begin
      addr_q <= req_wdata & AR_KEEP;
    end else if (data_go && addr_q[AR_AUTO]) begin
      addr_q[IDX_W-1:0] <= idx_advance(addr_q[IDX_W-1:0], idx_mask);
    end
  end

  // Registered response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (is_addr && !req_write)      rsp_rdata <= addr_q;
      else if (data_go && !req_write) rsp_rdata <= tbl_rd;
      else                            rsp_rdata <= '0;
    end
  end

  // Sticky error flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_access <= 1'b0;
      err_table  <= 1'b0;
    end else begin
      if (bad_acc) err_access <= 1'b1;
      if (bad_tbl) err_table  <= 1'b1;
    end
  end

  // Window re-evaluate strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_upd_valid <= 1'b0;
      win_upd_idx   <= '0;
    end else begin
      win_upd_valid <= wr_win;
      if (wr_win) win_upd_idx <= cur_idx[WIN_IW-1:0];
    end
  end

  // Vector lookup port
  always_comb begin
    ivt_pick = '0;
    for (int i = 0; i < IVT_DEPTH; i++)
      if (ivt_rd_idx == IVT_IW'(i)) ivt_pick = ivt_ent[i];
  end

  assign ivt_server = ivt_server_of(ivt_pick);
  assign ivt_prio   = ivt_prio_of(ivt_pick);
  assign ivt_node   = ivt_node_of(ivt_pick);
endmodule

// File: rtl/tap_checker.sv
module tap_checker
  import tap_pkg::*;
#(
  parameter int WIN_DEPTH = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_write,
  input logic                    rsp_valid,
  input logic                    err_access,
  input logic                    err_table,
  input logic [7:0]              ivt_server,
  input logic [WIN_DEPTH-1:0]    win_en,
  input logic [64*WIN_DEPTH-1:0] win_base,
  input logic [64*WIN_DEPTH-1:0] win_mask,
  input logic                    win_upd_valid,
  input logic [63:0]             addr_q
);
  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r2_rsp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r12_access_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_access |=> err_access);
  a_r5_table_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_table |=> err_table);
  a_r11_strobe_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    win_upd_valid |-> $past(req_valid && req_write));
  a_r8_server_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ivt_server[7:6]) == 0);
  a_r1_addr_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q & ~AR_KEEP) == 64'h0);
  a_r3_addr_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(addr_q));

  for (genvar g = 0; g < WIN_DEPTH; g++) begin : g_chk
    a_r9_off_window_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !win_en[g] |-> (win_base[g*64 +: 64] == 64'h0 && win_mask[g*64 +: 64] == 64'h0));
    a_r9_on_window_mask_top: assert property (@(posedge clk) disable iff (!rst_n)
      win_en[g] |-> (win_mask[g*64+50 +: 14] == 14'h3FFF));
  end
endmodule

bind tbl_access_port tap_checker #(.WIN_DEPTH(WIN_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .err_access(err_access), .err_table(err_table),
  .ivt_server(ivt_server), .win_en(win_en), .win_base(win_base),
  .win_mask(win_mask), .win_upd_valid(win_upd_valid), .addr_q(addr_q)
);

// File: tb/tbl_access_port_tb.sv
module tbl_access_port_tb;
  localparam int WD = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, req_full = 1'b1;
  logic [3:0]    req_off = '0;
  logic [63:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [63:0]   rsp_rdata;
  logic          err_access, err_table;
  logic [2:0]    ivt_rd_idx = '0;
  logic [7:0]    ivt_server, ivt_prio;
  logic [3:0]    ivt_node;
  logic [WD-1:0] win_en;
  logic [64*WD-1:0] win_base, win_mask;
  logic          win_upd_valid;
  logic [1:0]    win_upd_idx;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tbl_access_port u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_full(req_full), .req_off(req_off), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .err_access(err_access),
    .err_table(err_table), .ivt_rd_idx(ivt_rd_idx), .ivt_server(ivt_server),
    .ivt_prio(ivt_prio), .ivt_node(ivt_node), .win_en(win_en),
    .win_base(win_base), .win_mask(win_mask), .win_upd_valid(win_upd_valid),
    .win_upd_idx(win_upd_idx)
  );

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [3:0] off, input logic [63:0] d,
                        input bit full, output logic [63:0] rdat);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_off = off; req_wdata = d; req_full = full;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_full = 1'b1;
    rdat = rsp_rdata;
  endtask

  task automatic wr(input logic [3:0] off, input logic [63:0] d);
    logic [63:0] unused_r;
    access(1'b1, off, d, 1'b1, unused_r);
  endtask

  task automatic rd(input logic [3:0] off, output logic [63:0] r);
    access(1'b0, off, 64'h0, 1'b1, r);
  endtask

  // kind (0 write, 1 read-check), offset, write data, expected read data
  localparam int NV = 20;
  localparam logic [133:0] VEC [NV] = '{
    {2'd0, 4'h0, 64'h0002_0000_0000_0003, 64'h0},                     // R1
    {2'd1, 4'h0, 64'h0, 64'h0002_0000_0000_0003},                     // R1
    {2'd0, 4'h8, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},                     // R7
    {2'd1, 4'h8, 64'h0, 64'h0000_FFFF_0F00_0000},                     // R7 R2
    {2'd1, 4'h0, 64'h0, 64'h0002_0000_0000_0003},                     // R4
    {2'd0, 4'h0, 64'h8007_0000_0000_0006, 64'h0},                     // R3
    {2'd0, 4'h8, 64'h0000_0000_0000_1111, 64'h0},                     // R3
    {2'd0, 4'h8, 64'h0000_0000_0000_2222, 64'h0},                     // R3
    {2'd1, 4'h0, 64'h0, 64'h8007_0000_0000_0000},                     // R3 wrap
    {2'd0, 4'h0, 64'h8007_0000_0000_0006, 64'h0},                     // R3
    {2'd1, 4'h8, 64'h0, 64'h0000_0000_0000_1111},                     // R2
    {2'd1, 4'h8, 64'h0, 64'h0000_0000_0000_2222},                     // R2
    {2'd1, 4'h0, 64'h0, 64'h8007_0000_0000_0000},                     // R3
    {2'd0, 4'h0, 64'h0FF2_1234_5678_0001, 64'h0},                     // R1
    {2'd1, 4'h0, 64'h0, 64'h0002_0000_0000_0001},                     // R1
    {2'd0, 4'h0, 64'h8003_0000_0000_000F, 64'h0},                     // R6
    {2'd0, 4'h8, 64'h0000_0000_0000_DEAD, 64'h0},                     // R6
    {2'd1, 4'h0, 64'h0, 64'h8003_0000_0000_0000},                     // R3 R6
    {2'd0, 4'h0, 64'h0003_0000_0000_000F, 64'h0},                     // R6
    {2'd1, 4'h8, 64'h0, 64'h0}                                        // R6
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [63:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    chk("R13 err_access", 64'(err_access), 64'h0);
    chk("R13 err_table", 64'(err_table), 64'h0);
    chk("R13 win_en", 64'(win_en), 64'h0);
    chk("R13 strobe", 64'(win_upd_valid), 64'h0);
    rd(4'h0, r); chk("R13 addr reg", r, 64'h0);
    chk("R2 rsp_valid", 64'(rsp_valid), 64'h1);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][133:132] == 2'd0) wr(VEC[i][131:128], VEC[i][127:64]);
      else begin
        rd(VEC[i][131:128], r);
        chk($sformatf("R1-vector %0d (R2/R3/R4/R6/R7)", i), r, VEC[i][63:0]);
      end
    end

    // R8 vector lookup: entry 3 holds server 0xFF
    ivt_rd_idx = 3'd3; @(negedge clk);
    chk("R8 server", 64'(ivt_server), 64'h3F);
    chk("R8 prio", 64'(ivt_prio), 64'hFF);
    wr(4'h0, 64'h0002_0000_0000_0002);
    wr(4'h8, 64'h1234_5A07_F3FF_FFFF);
    chk("R11 no strobe on vector write", 64'(win_upd_valid), 64'h0);
    ivt_rd_idx = 3'd2; @(negedge clk);
    chk("R8 server 2", 64'(ivt_server), 64'h16);
    chk("R8 prio 2", 64'(ivt_prio), 64'h07);
    chk("R8 node 2", 64'(ivt_node), 64'h3);

    // R9 / R11 window entry 2
    wr(4'h0, 64'h0005_0000_0000_0002);
    wr(4'h8, 64'h80FF_FF00_0012_3457);
    chk("R11 strobe", 64'(win_upd_valid), 64'h1);
    chk("R11 strobe idx", 64'(win_upd_idx), 64'h2);
    chk("R9 enables", 64'(win_en), 64'h4);
    chk("R9 base", win_base[2*64 +: 64], 64'h0000_0123_4570_0000);
    chk("R9 mask", win_mask[2*64 +: 64], 64'hFFFC_FFFF_0000_0000);
    chk("R9 disabled base", win_base[0 +: 64], 64'h0);
    @(negedge clk);
    chk("R11 strobe one cycle", 64'(win_upd_valid), 64'h0);

    // R10 single-partition entry 1
    wr(4'h0, 64'h0005_0000_0000_0001);
    wr(4'h8, 64'hC000_0000_0FFF_FFFF);
    chk("R10 base", win_base[1*64 +: 64], 64'h0000_FFFF_FE00_0000);
    chk("R9 mask zero field", win_mask[1*64 +: 64], 64'hFFFC_0000_0000_0000);
    // R11 disabling write still strobes
    wr(4'h8, 64'h4000_0000_0FFF_FFFF);
    chk("R11 strobe on disable", 64'(win_upd_valid), 64'h1);
    chk("R11 idx on disable", 64'(win_upd_idx), 64'h1);
    chk("R9 disabled", 64'(win_en), 64'h4);
    chk("R9 disabled base zero", win_base[1*64 +: 64], 64'h0);

    // R5 unknown table
    wr(4'h0, 64'h800B_0000_0000_0001);
    wr(4'h8, 64'h0000_0000_0000_1234);
    chk("R5 err_table", 64'(err_table), 64'h1);
    rd(4'h0, r); chk("R5 index kept", r, 64'h800B_0000_0000_0001);
    rd(4'h8, r); chk("R5 read zero", r, 64'h0);
    chk("R12 err_access still clear", 64'(err_access), 64'h0);

    // R12 bad width / alignment
    access(1'b1, 4'h0, 64'h0002_0000_0000_0005, 1'b0, r);
    chk("R12 err_access narrow", 64'(err_access), 64'h1);
    rd(4'h0, r); chk("R12 addr unchanged", r, 64'h800B_0000_0000_0001);
    access(1'b1, 4'h4, 64'h0002_0000_0000_0006, 1'b1, r);
    rd(4'h0, r); chk("R12 misaligned ignored", r, 64'h800B_0000_0000_0001);
    access(1'b0, 4'h0, 64'h0, 1'b0, r);
    chk("R12 narrow read zero", r, 64'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule